// File: doc/BRIEF.md
# Split-Phase PIO Data-Port Bridge

This block sits between an 8-bit microcontroller's external data bus and a drive-side PIO cycle sequencer. The CPU never waits on the drive bus. A CPU read of a drive register only launches a device read. When the sequencer reports completion, the word is captured into a low-byte and a high-byte staging register. The CPU then fetches it from those registers. Writes to the 16-bit data port take their upper byte from a high-byte register that the CPU preloads. Writes to the other drive registers go out as single bytes.

A completion flag, mirrored onto an interrupt line under an enable, tells firmware when the next access may be launched. Two options speed up data-port streaming. The first is write posting: the CPU sees a data-port write as done at once, and one further access can be queued behind it. The second is read prefetch: after a data-port read the bridge fetches the next word on its own, so the following data-port read completes without waiting on the sequencer.

CPU address map (4-bit address): 0x0 to 0x7 form the drive register window, and window offset 0 is the data port. 0x8 is the low staging byte (read only). 0x9 is the high staging byte (read/write). 0xA is status: bit0 is the completion flag, bit1 is ready (read only). 0xB is control: bit0 is the interrupt enable, bit1 is the prefetch enable, bit2 is the posting enable. All other addresses read 0x00.

Top module: `pio_port_bridge`

## Requirements
- R1: After reset, low = high = control = 0x00, status reads 0x02 (ready, no completion), irq is 0 and seq_req is 0.
- R2: A CPU read of window offset k (address 0x0 to 0x7) while ready returns 0x00 in the same cycle. It launches exactly one sequencer read of offset k, and seq_wide is 1 exactly when k = 0.
- R3: When a foreground read completes, low (0x8) takes seq_rdata[7:0]. High (0x9) takes seq_rdata[15:8] only if the offset was 0, and an 8-bit read leaves high unchanged. Status bit0 and bit1 both become 1.
- R4: A CPU write of byte b to offset 0 issues one wide write with data {high, b}. A write to offset k != 0 issues an 8-bit write with data {0x00, b}.
- R5: While status bit1 is 0, CPU reads and writes of the window launch nothing and change no request.
- R6: Status bit0 clears when an access is accepted that leaves the bridge not ready. Writing 1 to status bit0 clears it. Writing 0 leaves it unchanged.
- R7: irq equals status bit0 AND control bit0.
- R8: With control bit2 set, a data-port write leaves status at 0x03. An access accepted while that write is still in flight is held, with status 0x00, and is issued as soon as the write completes.
- R9: With control bit1 set, a completed data-port read is followed by an automatic data-port read. The next CPU data-port read then loads the stored word into low/high at once, status reading 0x03 in the next cycle, and launches another automatic read.
- R10: A CPU data-port read while an automatic read is in flight leaves the bridge not ready until that read completes, and delivers its word.
- R11: A window write, or a window read of an offset other than 0, discards a stored prefetched word. The next data-port read then fetches a fresh word from the sequencer.
- R12: seq_req and its address, direction and data stay unchanged from launch until seq_done. A new request may follow in the cycle after seq_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_rdata | output | 8 | CPU read byte, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| seq_req | output | 1 | Request to the sequencer, held until seq_done |
| seq_we | output | 1 | Request is a write |
| seq_addr | output | 3 | Drive register offset |
| seq_wide | output | 1 | 16-bit transfer (data port) |
| seq_wdata | output | 16 | Write word |
| seq_done | input | 1 | Completion pulse from the sequencer |
| seq_rdata | input | 16 | Read word, valid with seq_done |

## Verification
All eight window offsets are swept, once for reads and once for writes, each with a distinct byte and a distinct sequencer word. This separates the 16-bit data-port path from the 8-bit path, and shows whether the high staging byte is updated or left alone. Accesses issued while a cycle is in flight show that busy accesses are dropped, while with posting on they are held instead. A sequence of prefetch hits, a claim of an in-flight prefetch, and discards caused by a non-data-port read and by a write distinguishes stored, in-flight and stale prefetched words by their data values.

// File: rtl/pio_port_bridge.sv
module pio_port_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  cpu_rdata,
  output logic        irq,
  output logic        seq_req,
  output logic        seq_we,
  output logic [2:0]  seq_addr,
  output logic        seq_wide,
  output logic [15:0] seq_wdata,
  input  logic        seq_done,
  input  logic [15:0] seq_rdata
);
  typedef enum logic [1:0] {K_FG = 2'd0, K_POST = 2'd1, K_PF = 2'd2} kind_t;

  logic        req_q, we_q;
  logic [2:0]  addr_q;
  logic [15:0] wdata_q;
  kind_t       kind_q;
  logic        pend_v, pend_we;
  logic [2:0]  pend_addr;
  logic [15:0] pend_wdata;
  logic        pf_v;
  logic [15:0] pf_data;
  logic        avail_q, stat_q, ien, pf_en, post_en;
  logic [7:0]  lo_q, hi_q;

  wire        acc     = (cpu_wr | cpu_rd) & ~cpu_addr[3];
  wire        acc_dp  = cpu_addr[2:0] == 3'd0;
  wire [15:0] acc_wd  = acc_dp ? {hi_q, cpu_wdata} : {8'h00, cpu_wdata};
  wire        take    = acc & avail_q;
  wire        fin     = req_q & seq_done;
  wire        dp_rd   = take & ~cpu_wr & acc_dp & pf_en;
  wire        hit     = dp_rd & pf_v;
  wire        claim   = dp_rd & req_q & (kind_q == K_PF);
  wire        norm    = take & ~hit & ~claim;
  wire        hold    = norm & req_q & ~fin;
  wire        fg_fin  = fin & (kind_q == K_FG);
  wire        pf_next = fg_fin & ~we_q & (addr_q == 3'd0) & pf_en;
  wire        pend_go = fin & (kind_q != K_FG) & pend_v;
  wire        w1c     = cpu_wr & (cpu_addr == 4'hA) & cpu_wdata[0];

  logic        iss, i_pf, i_we;
  logic [2:0]  i_addr;
  logic [15:0] i_wd;
  kind_t       i_kind;

  always_comb begin
    iss = 1'b0; i_pf = 1'b0; i_we = 1'b0; i_addr = 3'd0; i_wd = 16'h0;
    if (hit || (claim && fin) || pf_next) begin
      iss = 1'b1; i_pf = 1'b1;
    end else if (norm && !hold) begin
      iss = 1'b1; i_we = cpu_wr; i_addr = cpu_addr[2:0]; i_wd = acc_wd;
    end else if (pend_go) begin
      iss = 1'b1; i_we = pend_we; i_addr = pend_addr; i_wd = pend_wdata;
    end
    if (i_pf) i_kind = K_PF;
    else if (i_we && i_addr == 3'd0 && post_en) i_kind = K_POST;
    else i_kind = K_FG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0; we_q <= 1'b0; addr_q <= 3'd0; wdata_q <= 16'h0; kind_q <= K_FG;
      pend_v <= 1'b0; pend_we <= 1'b0; pend_addr <= 3'd0; pend_wdata <= 16'h0;
      pf_v <= 1'b0; pf_data <= 16'h0;
      avail_q <= 1'b1; stat_q <= 1'b0; ien <= 1'b0; pf_en <= 1'b0; post_en <= 1'b0;
      lo_q <= 8'h00; hi_q <= 8'h00;
    end else begin
      if (iss) begin
        req_q <= 1'b1; we_q <= i_we; addr_q <= i_addr; wdata_q <= i_wd; kind_q <= i_kind;
      end else if (fin) req_q <= 1'b0;
      else if (claim) kind_q <= K_FG;

      if (hold || (claim && !fin)) begin
        avail_q <= 1'b0; stat_q <= 1'b0;
      end else if (iss && !i_pf) begin
        avail_q <= i_kind == K_POST; stat_q <= i_kind == K_POST;
      end else if (hit || (claim && fin) || fg_fin) begin
        avail_q <= 1'b1; stat_q <= 1'b1;
      end else if (w1c) stat_q <= 1'b0;

      if (hold) begin
        pend_v <= 1'b1; pend_we <= cpu_wr; pend_addr <= cpu_addr[2:0]; pend_wdata <= acc_wd;
      end else if (pend_go) pend_v <= 1'b0;

      if (norm || hit) pf_v <= 1'b0;
      else if (fin && kind_q == K_PF && !pend_v && !take) begin
        pf_v <= 1'b1; pf_data <= seq_rdata;
      end

      if (cpu_wr && cpu_addr == 4'h9) hi_q <= cpu_wdata;
      if (cpu_wr && cpu_addr == 4'hB) {post_en, pf_en, ien} <= cpu_wdata[2:0];
      if (hit) {hi_q, lo_q} <= pf_data;
      else if (claim && fin) {hi_q, lo_q} <= seq_rdata;
      else if (fg_fin && !we_q) begin
        lo_q <= seq_rdata[7:0];
        if (addr_q == 3'd0) hi_q <= seq_rdata[15:8];
      end
    end
  end

  always_comb begin
    case (cpu_addr)
      4'h8:    cpu_rdata = lo_q;
      4'h9:    cpu_rdata = hi_q;
      4'hA:    cpu_rdata = {6'd0, avail_q, stat_q};
      4'hB:    cpu_rdata = {5'd0, post_en, pf_en, ien};
      default: cpu_rdata = 8'h00;
    endcase
  end

  assign irq       = stat_q & ien;
  assign seq_req   = req_q;
  assign seq_we    = we_q;
  assign seq_addr  = addr_q;
  assign seq_wide  = addr_q == 3'd0;
  assign seq_wdata = wdata_q;
endmodule

// File: rtl/pio_port_bridge_chk.sv
module pio_port_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cpu_addr,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic        irq,
  input logic        seq_req,
  input logic        seq_we,
  input logic [2:0]  seq_addr,
  input logic [15:0] seq_wdata,
  input logic        seq_done,
  input logic        avail,
  input logic        stat,
  input logic [1:0]  kind,
  input logic        pend_v
);
  wire win_acc = (cpu_wr | cpu_rd) & ~cpu_addr[3];

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && !seq_done |=> seq_req && $stable(seq_addr) && $stable(seq_we) && $stable(seq_wdata));

  assert_busy_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_acc && !avail && !seq_done |=> $stable(seq_req) && $stable(seq_addr) && $stable(seq_we));

  assert_fg_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && seq_done && kind == 2'd0 |=> avail && stat);

  assert_flag_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat |-> avail);

  assert_irq_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> avail);

  assert_posted_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && kind == 2'd1 && !pend_v |-> avail);
endmodule

bind pio_port_bridge pio_port_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .irq(irq), .seq_req(seq_req), .seq_we(seq_we), .seq_addr(seq_addr),
  .seq_wdata(seq_wdata), .seq_done(seq_done), .avail(avail_q), .stat(stat_q),
  .kind(kind_q), .pend_v(pend_v)
);

// File: tb/test_pio_port_bridge.sv
module test_pio_port_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cpu_addr = 4'h0;
  logic [7:0] cpu_wdata = 8'h00, cpu_rdata;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, irq;
  logic seq_req, seq_we, seq_wide, seq_done = 1'b0;
  logic [2:0] seq_addr;
  logic [15:0] seq_wdata, seq_rdata = 16'h0;

  pio_port_bridge i_pio_port_bridge (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, nops = 0, cnt = 0;
  bit ended = 0;
  logic        lg_we [64];
  logic [2:0]  lg_addr [64];
  logic        lg_wide [64];
  logic [15:0] lg_wd [64];

  function automatic logic [15:0] rv(int n);
    logic [7:0] a = 8'(n * 37 + 5);
    logic [7:0] b = 8'(n * 11 + 96);
    return {a, b};
  endfunction

  initial forever begin
    @(negedge clk);
    if (!rst_n) begin seq_done = 1'b0; cnt = 0; end
    else if (seq_done) begin seq_done = 1'b0; cnt = 0; end
    else if (seq_req) begin
      cnt++;
      if (cnt == LAT && nops < 64) begin
        lg_we[nops] = seq_we; lg_addr[nops] = seq_addr;
        lg_wide[nops] = seq_wide; lg_wd[nops] = seq_wdata;
        seq_rdata = rv(nops); seq_done = 1'b1; nops++;
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic wr, logic [3:0] a, logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = ~wr;
    #1 q = cpu_rdata;
    @(posedge clk);
    #1 cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    logic [7:0] q;
    op(1'b1, a, d, q);
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] q);
    op(1'b0, a, 8'h00, q);
  endtask

  task automatic wait_done(string tag);
    logic [7:0] q;
    for (int i = 0; i < 40; i++) begin
      rd(4'hA, q);
      if (q[0]) return;
    end
    nchk++; nerr++;
    $display("FAIL %s completion never seen actual=0 expected=1", tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    end
    $finish;
  end

  initial begin
    logic [7:0] q, exp_hi;
    int m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'hA, q); chk("R1 status", q, 8'h02);
    rd(4'hB, q); chk("R1 control", q, 8'h00);
    rd(4'h8, q); chk("R1 low", q, 8'h00);
    rd(4'h9, q); chk("R1 high", q, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 seq_req", seq_req, 1'b0);

    // R2 R3 read sweep over all offsets
    exp_hi = 8'h00;
    for (int k = 0; k < 8; k++) begin
      m = nops;
      rd(4'(k), q); chk("R2 window read data", q, 8'h00);
      wait_done("R3");
      chk("R2 one op", 16'(nops), 16'(m + 1));
      chk("R2 addr", lg_addr[m], 16'(k));
      chk("R2 dir", lg_we[m], 1'b0);
      chk("R2 wide", lg_wide[m], k == 0);
      if (k == 0) exp_hi = rv(m)[15:8];
      rd(4'h8, q); chk("R3 low", q, rv(m)[7:0]);
      rd(4'h9, q); chk("R3 high", q, exp_hi);
      rd(4'hA, q); chk("R3 status", q, 8'h03);
    end

    // R4 write sweep over all offsets
    for (int k = 0; k < 8; k++) begin
      m = nops;
      wr(4'h9, 8'hB0 + 8'(k));
      wr(4'(k), 8'h40 + 8'(k));
      wait_done("R4");
      chk("R4 one op", 16'(nops), 16'(m + 1));
      chk("R4 dir", lg_we[m], 1'b1);
      chk("R4 wide", lg_wide[m], k == 0);
      chk("R4 data", lg_wd[m], k == 0 ? {8'hB0, 8'h40} : {8'h00, 8'h40 + 8'(k)});
    end

    // R5 R6 R12 busy accesses dropped
    m = nops;
    rd(4'h3, q);
    chk("R12 req up", seq_req, 1'b1);
    chk("R12 addr", seq_addr, 3'd3);
    rd(4'hA, q); chk("R6 cleared on launch", q, 8'h00);
    wr(4'h5, 8'h77);
    rd(4'h6, q);
    wait_done("R5");
    idle(10);
    chk("R5 single op", 16'(nops), 16'(m + 1));
    chk("R5 addr", lg_addr[m], 16'd3);
    rd(4'h8, q); chk("R5 low", q, rv(m)[7:0]);

    // R6 R7 flag clearing and interrupt
    chk("R7 irq disabled", irq, 1'b0);
    wr(4'hB, 8'h01);
    chk("R7 irq enabled", irq, 1'b1);
    wr(4'hA, 8'h00);
    rd(4'hA, q); chk("R6 write 0 keeps", q, 8'h03);
    wr(4'hA, 8'h01);
    rd(4'hA, q); chk("R6 write 1 clears", q, 8'h02);
    chk("R7 irq follows", irq, 1'b0);

    // R8 posting
    wr(4'hB, 8'h05);
    m = nops;
    wr(4'h9, 8'hC1);
    wr(4'h0, 8'h22);
    chk("R8 irq on post", irq, 1'b1);
    rd(4'hA, q); chk("R8 posted ready", q, 8'h03);
    wr(4'h9, 8'hC2);
    wr(4'h0, 8'h33);
    rd(4'hA, q); chk("R8 held not ready", q, 8'h00);
    rd(4'hA, q); chk("R8 held issued", q, 8'h03);
    idle(12);
    chk("R8 two ops", 16'(nops), 16'(m + 2));
    chk("R8 first data", lg_wd[m], 16'hC122);
    chk("R8 second data", lg_wd[m + 1], 16'hC233);
    chk("R8 second wide", lg_wide[m + 1], 1'b1);

    // R9 prefetch
    wr(4'hB, 8'h02);
    m = nops;
    rd(4'h0, q);
    wait_done("R9");
    idle(12);
    chk("R9 auto read issued", 16'(nops), 16'(m + 2));
    chk("R9 auto addr", lg_addr[m + 1], 16'd0);
    chk("R9 auto dir", lg_we[m + 1], 1'b0);
    rd(4'h0, q);
    rd(4'hA, q); chk("R9 hit ready", q, 8'h03);
    rd(4'h8, q); chk("R9 hit low", q, rv(m + 1)[7:0]);
    rd(4'h9, q); chk("R9 hit high", q, rv(m + 1)[15:8]);
    idle(12);
    chk("R9 next auto read", 16'(nops), 16'(m + 3));

    // R10 claim in-flight prefetch
    m = nops;
    rd(4'h0, q);
    rd(4'h0, q);
    rd(4'hA, q); chk("R10 waits", q, 8'h00);
    wait_done("R10");
    rd(4'h8, q); chk("R10 low", q, rv(m)[7:0]);
    rd(4'h9, q); chk("R10 high", q, rv(m)[15:8]);
    idle(12);
    chk("R10 ops", 16'(nops), 16'(m + 2));

    // R11 discard on non-data-port read
    rd(4'h3, q);
    wait_done("R11");
    m = nops;
    rd(4'h0, q);
    rd(4'hA, q); chk("R11 fresh after read", q, 8'h00);
    wait_done("R11");
    rd(4'h8, q); chk("R11 low after read", q, rv(m)[7:0]);
    idle(12);

    // R11 discard on write
    wr(4'h0, 8'h5C);
    wait_done("R11");
    m = nops;
    rd(4'h0, q);
    rd(4'hA, q); chk("R11 fresh after write", q, 8'h00);
    wait_done("R11");
    rd(4'h9, q); chk("R11 high after write", q, rv(m)[15:8]);
    chk("R11 addr", lg_addr[m], 16'd0);
    idle(12);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    end
    $finish;
  end
endmodule